// File: doc/BRIEF.md
# Accumulator Normalisation-Count Unit with Status Flags

This block takes one of two 40-bit accumulator operands and finds how far it could be shifted left before its sign changes. Each operand is a 32-bit data word with 8 guard bits above it (bits 39:32). A priority encoder scans the operand for the highest bit that differs from bit 39. The unit turns that position into a signed normalisation count and writes it, in a fixed format, to a registered 40-bit destination one clock after the operation is issued.

Five status flags are computed from the result and held in registers: a mode-selectable condition flag (DC), negative (N), zero (Z), overflow (V) and greater-than (GT). A 3-bit mode input chooses what DC means for each operation. When an operation is issued as conditionally executed, the destination is still written but all five flags keep their old values. Instruction decode, the register file and condition evaluation live outside this unit.

Top module: `msbd_unit`

## Requirements
- R1: With `src_sel`=0 the operand is `src_a`; with `src_sel`=1 it is `src_b`.
- R2: One cycle after an issue (`op_valid`=1), `dest` holds the count C, where C is the number of bits below bit 39 that equal bit 39 before the first differing bit, minus 8. C is placed in bits 31:16, bits 39:32 repeat its sign, bits 15:0 are zero, and `dest_vld` is 1 in that cycle.
- R3: An operand of all zeros or all ones gives the largest count, 31 (`dest`=0x00_001F_0000). An operand whose bit 38 differs from bit 39 gives the smallest, -8 (`dest`=0xFF_FFF8_0000).
- R4: For an unconditional issue (`op_cond`=0), the flags update with the destination. N = bit 39 of the result, Z = 1 when all 40 result bits are 0, V = 0, and GT = 1 when the result is nonzero and N=0.
- R5: For a conditional issue (`op_cond`=1), all five flags keep their previous values, and `dest` is still written as in R2.
- R6: `cs_mode` values 000, 011, 110 and 111 clear DC on an unconditional issue.
- R7: `cs_mode`=001 sets DC to N of the result, and `cs_mode`=010 sets DC to Z.
- R8: `cs_mode`=100 sets DC when the result is strictly positive, and `cs_mode`=101 sets DC when the result is zero or positive.
- R9: In a cycle with `op_valid`=0, `dest` and the flags keep their values, and one cycle later `dest_vld` is 0.
- R10: A synchronous reset (`rst`=1) clears `dest`, `dest_vld` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_cond | input | 1 | Operation is conditionally executed (flags frozen) |
| src_sel | input | 1 | Operand select: 0 = src_a, 1 = src_b |
| cs_mode | input | 3 | DC flag definition for this operation |
| src_a | input | 40 | First accumulator operand |
| src_b | input | 40 | Second accumulator operand |
| dest | output | 40 | Formatted normalisation count |
| dest_vld | output | 1 | Destination written in previous cycle |
| flag_dc | output | 1 | Mode-selected condition flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_gt | output | 1 | Greater-than flag |

## Verification
Uniform random operands almost always have only a few redundant sign bits. The extreme counts near -8 and near 31, and a zero count, which is the only way to raise Z and exercise the zero-based DC modes, would then hardly ever appear. The stimulus therefore shifts a random word arithmetically right by a random distance, which spreads the counts over the whole range. Directed vectors add the all-zero and all-one operands and a pattern that gives a count of exactly 0. Modes, operand select and conditional execution are mixed at random so that frozen flags are followed by updates under every DC mode.

// File: rtl/msbd_pkg.sv
package msbd_pkg;
    parameter int ACC_W   = 40;
    parameter int GUARD_W = 8;
    parameter int LOWZ_W  = 16;

    localparam int WORD_W  = ACC_W - GUARD_W;
    localparam int FIELD_W = ACC_W - LOWZ_W;
    localparam int CNT_W   = $clog2(ACC_W) + 1;

    typedef logic [ACC_W-1:0]        acc_t;
    typedef logic signed [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        DC_CARRY = 3'b000,
        DC_NEG   = 3'b001,
        DC_ZERO  = 3'b010,
        DC_OVF   = 3'b011,
        DC_GT    = 3'b100,
        DC_GE    = 3'b101,
        DC_RSV6  = 3'b110,
        DC_RSV7  = 3'b111
    } dc_mode_e;

    typedef struct packed {
        logic dc;
        logic n;
        logic z;
        logic v;
        logic gt;
    } flags_t;

    // Place a signed count in the upper field, sign-filled, low part zero.
    function automatic acc_t format_result(cnt_t c);
        return {{(FIELD_W - CNT_W){c[CNT_W-1]}}, c, {LOWZ_W{1'b0}}};
    endfunction

    function automatic logic dc_select(dc_mode_e m, logic n, logic z, logic gt);
        case (m)
            DC_NEG:  return n;
            DC_ZERO: return z;
            DC_GT:   return gt;
            DC_GE:   return ~n;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/msbd_opsel.sv
module msbd_opsel
    import msbd_pkg::*;
#(
    parameter int NSRC = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NSRC-1:0][ACC_W-1:0] srcs,
    output acc_t                  y
);
    always_comb begin
        y = srcs[0];
        for (int i = 1; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) y = srcs[i];
        end
    end
endmodule

// File: rtl/msbd_prienc.sv
module msbd_prienc
    import msbd_pkg::*;
#(
    parameter int W     = ACC_W,
    parameter int SHIFT = GUARD_W
) (
    input  logic [W-1:0] val,
    output cnt_t         norm
);
    localparam int SCAN = W - 1;

    logic [SCAN-1:0] diff;
    logic [SCAN-1:0] above;
    logic [CNT_W-1:0] rsb;

    // Mark bits that differ from the sign, and whether any such bit is higher.
    genvar g;
    generate
        for (g = 0; g < SCAN; g++) begin : g_scan
            assign diff[g] = val[g] ^ val[W-1];
            if (g == SCAN - 1) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_rest
                assign above[g] = above[g+1] | diff[g+1];
            end
        end
    endgenerate

    always_comb begin
        rsb = CNT_W'(SCAN);
        for (int i = 0; i < SCAN; i++) begin
            if (diff[i] && !above[i]) rsb = CNT_W'(SCAN - 1 - i);
        end
    end

    assign norm = cnt_t'(rsb) - cnt_t'(SHIFT);
endmodule

// File: rtl/msbd_flags.sv
module msbd_flags
    import msbd_pkg::*;
(
    input  acc_t     res,
    input  dc_mode_e mode,
    output flags_t   f
);
    logic n, z, gt;

    always_comb begin
        n    = res[ACC_W-1];
        z    = (res == '0);
        gt   = ~n & ~z;
        f.n  = n;
        f.z  = z;
        f.v  = 1'b0;
        f.gt = gt;
        f.dc = dc_select(mode, n, z, gt);
    end
endmodule

// File: rtl/msbd_unit.sv
module msbd_unit
    import msbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_cond,
    input  logic              src_sel,
    input  logic [2:0]        cs_mode,
    input  logic [ACC_W-1:0]  src_a,
    input  logic [ACC_W-1:0]  src_b,
    output logic [ACC_W-1:0]  dest,
    output logic              dest_vld,
    output logic              flag_dc,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_gt
);
    acc_t   operand;
    cnt_t   norm;
    acc_t   result;
    flags_t next_f;
    flags_t flags_q;
    acc_t   dest_q;
    logic   vld_q;

    msbd_opsel #(.NSRC(2)) i_opsel (
        .sel  (src_sel),
        .srcs ({src_b, src_a}),
        .y    (operand)
    );

    msbd_prienc #(.W(ACC_W), .SHIFT(GUARD_W)) i_enc (
        .val  (operand),
        .norm (norm)
    );

    assign result = format_result(norm);

    msbd_flags i_flags (
        .res  (result),
        .mode (dc_mode_e'(cs_mode)),
        .f    (next_f)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q  <= '0;
            vld_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) begin
                dest_q <= result;
                if (!op_cond) flags_q <= next_f;
            end
        end
    end

    assign dest     = dest_q;
    assign dest_vld = vld_q;
    assign flag_dc  = flags_q.dc;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_v   = flags_q.v;
    assign flag_gt  = flags_q.gt;
endmodule

// File: rtl/msbd_chk.sv
module msbd_chk
    import msbd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_cond,
    input logic [ACC_W-1:0] dest,
    input logic             dest_vld,
    input logic             flag_dc,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic             flag_gt
);
    assert_low_field_R2: assert property (@(posedge clk) disable iff (rst)
        dest_vld |-> dest[LOWZ_W-1:0] == '0);

    assert_issue_valid_R2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> dest_vld);

    assert_n_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_cond) |=> flag_n == dest[ACC_W-1]);

    assert_z_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_cond) |=> flag_z == (dest == '0));

    assert_gt_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(flag_gt && (flag_n || flag_z)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        !flag_v);

    assert_cond_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_cond) |=> $stable({flag_dc, flag_n, flag_z, flag_v, flag_gt}));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(dest) && !dest_vld
                       && $stable({flag_dc, flag_n, flag_z, flag_gt})));
endmodule

bind msbd_unit msbd_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_cond  (op_cond),
    .dest     (dest),
    .dest_vld (dest_vld),
    .flag_dc  (flag_dc),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_gt  (flag_gt)
);

// File: tb/test_msbd_unit.sv
`timescale 1ns/1ps
module test_msbd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_cond, src_sel;
    logic [2:0]  cs_mode;
    logic [39:0] src_a, src_b;
    logic [39:0] dest;
    logic        dest_vld, flag_dc, flag_n, flag_z, flag_v, flag_gt;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [4:0] exp_f;   // {dc,n,z,v,gt}

    always #2.5 clk = ~clk;

    msbd_unit i_msbd_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_cond(op_cond),
        .src_sel(src_sel), .cs_mode(cs_mode), .src_a(src_a), .src_b(src_b),
        .dest(dest), .dest_vld(dest_vld), .flag_dc(flag_dc), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
    );

    function automatic logic [39:0] ref_result(logic [39:0] x);
        int r = 0;
        logic run = 1'b1;
        logic signed [23:0] c;
        for (int i = 38; i >= 0; i--) begin
            if (run && x[i] == x[39]) r++;
            else run = 1'b0;
        end
        c = 24'(r - 8);
        return {c, 16'h0000};
    endfunction

    function automatic logic [4:0] ref_flags(logic [39:0] r, logic [2:0] m);
        logic n, z, gt, dc;
        n  = r[39];
        z  = (r == 40'h0);
        gt = !n && !z;
        case (m)
            3'b001:  dc = n;
            3'b010:  dc = z;
            3'b100:  dc = gt;
            3'b101:  dc = !n;
            default: dc = 1'b0;
        endcase
        return {dc, n, z, 1'b0, gt};
    endfunction

    function automatic string dc_tag(logic [2:0] m);
        case (m)
            3'b001, 3'b010: return "R7";
            3'b100, 3'b101: return "R8";
            default:        return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [39:0] a, logic [39:0] b, logic sel,
                         logic cond, logic [2:0] m, string rtag);
        logic [39:0] opnd, er;
        logic [4:0]  prev;
        opnd = sel ? b : a;
        er   = ref_result(opnd);
        prev = exp_f;
        src_a = a; src_b = b; src_sel = sel; op_cond = cond;
        cs_mode = m; op_valid = 1'b1;
        @(negedge clk);
        if (!cond) exp_f = ref_flags(er, m);
        check(rtag, 64'(dest), 64'(er));
        check("R2 valid", 64'(dest_vld), 64'd1);
        if (cond) check("R5 flags frozen", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), 64'(prev));
        else begin
            check("R4 flags", 64'({flag_n, flag_z, flag_v, flag_gt}), 64'(exp_f[3:0]));
            check(dc_tag(m), 64'(flag_dc), 64'(exp_f[4]));
        end
        op_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; op_valid = 1'b0; op_cond = 1'b0; src_sel = 1'b0;
        cs_mode = 3'b000; src_a = '0; src_b = '0;
        exp_f = 5'b0;
        repeat (3) @(negedge clk);
        check("R10 dest", 64'(dest), 64'd0);
        check("R10 vld", 64'(dest_vld), 64'd0);
        check("R10 flags", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), 64'd0);
        rst = 1'b0;

        // R3 extremes
        apply(40'h00_0000_0000, 40'hFF_0000_0000, 1'b0, 1'b0, 3'b101, "R3 zero");
        check("R3 zero val", 64'(dest), 64'h00_001F_0000);
        apply(40'h12_3456_789A, 40'hFF_FFFF_FFFF, 1'b1, 1'b0, 3'b001, "R3 ones");
        apply(40'h40_0000_0000, 40'h0, 1'b0, 1'b0, 3'b100, "R3 min");
        check("R3 min val", 64'(dest), 64'hFF_FFF8_0000);
        // count exactly zero -> Z, zero-mode DC (R7)
        apply(40'h00_4000_0000, 40'h0, 1'b0, 1'b0, 3'b010, "R2 zero count");
        check("R7 zero dc", 64'(flag_dc), 64'd1);
        // R1 select b versus a
        apply(40'h00_0000_0001, 40'h80_0000_0000, 1'b1, 1'b0, 3'b000, "R1 sel b");
        apply(40'h00_0000_0001, 40'h80_0000_0000, 1'b0, 1'b1, 3'b000, "R1 sel a");
        // R5 conditional keeps flags while dest written
        apply(40'h00_0000_0000, 40'h0, 1'b0, 1'b1, 3'b010, "R5 dest");
        // R6 reserved modes
        apply(40'h00_0000_0000, 40'h0, 1'b0, 1'b0, 3'b110, "R2");
        apply(40'h00_0000_0000, 40'h0, 1'b0, 1'b0, 3'b111, "R2");
        apply(40'hC0_0000_0000, 40'h0, 1'b0, 1'b0, 3'b011, "R2");
        // R9 idle hold
        held = dest;
        @(negedge clk);
        check("R9 dest", 64'(dest), 64'(held));
        check("R9 vld", 64'(dest_vld), 64'd0);
        check("R9 flags", 64'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), 64'(exp_f));

        for (int k = 0; k < 800; k++) begin
            logic [39:0] a, b, w;
            int sh;
            w  = {8'($urandom), $urandom};
            sh = int'($urandom_range(0, 40));
            a  = (sh == 40) ? {40{w[39]}} : 40'($signed(w) >>> sh);
            b  = {8'($urandom), $urandom} >>> $urandom_range(0, 39);
            apply(a, b, 1'($urandom), ($urandom_range(0, 3) == 0), 3'($urandom), "R2 random");
            if ($urandom_range(0, 7) == 0) begin
                held = dest;
                @(negedge clk);
                check("R9 idle", 64'({dest, dest_vld}), 64'({held, 1'b0}));
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule